// File: doc/BRIEF.md
# Memory Barrier and Sleep Controller

This unit executes a barrier instruction on the issue side of a pipeline. The decoder hands it a 5-bit immediate through a ready/valid handshake. From the moment the unit accepts the request it holds issue stalled. It waits until the instruction-fetch and data access counters chosen by the immediate have drained to zero, then waits a fixed settle time that depends on the bus option. After that it either releases the PC advance or places the core in a low-power state.

Two low bits of the immediate choose which counters to wait for, and the bit is clear for a side that must be waited on. When the immediate asks to wait on the instruction side only, the unit also pulses the branch-target-cache and prefetch-buffer flush strobes. The two high bits pick one of three low-power states. Each state drives its own output until any wakeup bit goes high. When the MMU is enabled, bit 4 of the immediate marks the request as privileged. Such a request issued in user mode raises a privileged-instruction exception in place of any barrier action.

Top module: `barrier_sleep_ctl`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `stall`, `pc_adv`, both flush strobes, all three low-power outputs and `exc_valid` are 0.
- R2: When the accepted immediate has bit 0 = 0, the unit stays stalled while `ifetch_pend` is nonzero. Each such cycle adds one cycle to the latency. When bit 0 = 1, `ifetch_pend` has no effect on timing.
- R3: When the accepted immediate has bit 1 = 0, the unit stays stalled while `data_pend` is nonzero. When bit 1 = 1, `data_pend` has no effect on timing.
- R4: A non-faulting request without low-power entry keeps `stall` high for exactly FIX+N cycles after acceptance. FIX is SIMPLE_LAT (2) when COHERENT=0 and COHERENT_LAT (8) when COHERENT=1. N is the number of cycles in which a selected counter was still nonzero. `pc_adv` is high for one cycle only, in the last stalled cycle.
- R5: When the immediate bits [1:0] are 2'b10, `btc_flush` and `pfb_flush` pulse together in the `pc_adv` cycle. Otherwise they stay low.
- R6: Immediate bits [4:3] select the low-power state: 2'b10 is sleep (`lp_sleep`), 2'b01 is hibernate (`lp_hibernate`), 2'b11 is suspend (`lp_suspend`), and 2'b00 is none. The selected output rises in cycle FIX+N-1 after acceptance. At most one of the three outputs is high at a time, and `stall` stays high while it is.
- R7: In the low-power state, the output falls in the same cycle that any bit of `wake` is 1. `pc_adv` follows in the next cycle. The total stall is FIX+N+W+1 cycles, where W is the number of full cycles spent waiting for wakeup.
- R8: When `mmu_on`, `user_mode` and immediate bit 4 are all 1 at acceptance, `exc_valid` pulses for one cycle with `exc_code` = PRIV_CODE (default 5'b00111). In that case `stall` is high for that single cycle only, and no `pc_adv`, flush or low-power output occurs.
- R9: No exception is raised when `mmu_on` is 0, when `user_mode` is 0, or when immediate bit 4 is 0. In those cases the request completes normally.
- R10: `req_ready` is low from acceptance until the unit returns to idle. A request held valid in that time is accepted afterwards and executed, not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Decoded barrier request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_imm | input | 5 | Barrier immediate |
| ifetch_pend | input | CNT_W | Outstanding instruction-side accesses |
| data_pend | input | CNT_W | Outstanding data-side accesses |
| user_mode | input | 1 | Core runs in user mode |
| mmu_on | input | 1 | MMU enabled, privilege checks active |
| wake | input | WAKE_W | Wakeup request bits |
| stall | output | 1 | Hold instruction issue |
| btc_flush | output | 1 | Branch target cache clear pulse |
| pfb_flush | output | 1 | Prefetch buffer empty pulse |
| lp_sleep | output | 1 | Sleep state active |
| lp_hibernate | output | 1 | Hibernate state active |
| lp_suspend | output | 1 | Suspend state active |
| exc_valid | output | 1 | Privileged-instruction exception pulse |
| exc_code | output | 5 | Exception cause, valid with exc_valid |
| pc_adv | output | 1 | Advance PC by 4 |

## Verification
The bench builds the unit with COHERENT=1, CNT_W=4 and WAKE_W=3. This makes the settle window eight cycles long, so the counter branch of the settle timer is generated and counts through six states. Three wake bits let each wakeup come from a different bit position. The immediates cover every wait selection, each low-power code with and without a privilege fault, and a request held pending across a busy barrier. The drain windows run from zero to six cycles, and the unselected counter is held nonzero to show it is ignored.

// File: rtl/barrier_pkg.sv
`timescale 1ns/1ps
package barrier_pkg;
   localparam int IMM_W = 5;
   localparam int EC_W  = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DRAIN,
      ST_SETTLE,
      ST_SLEEP,
      ST_DONE,
      ST_EXC
   } bst_e;

   typedef enum logic [1:0] {
      LP_NONE  = 2'b00,
      LP_HIB   = 2'b01,
      LP_SLEEP = 2'b10,
      LP_SUSP  = 2'b11
   } lp_e;
endpackage

// File: rtl/barrier_drain.sv
`timescale 1ns/1ps
module barrier_drain #(
   parameter int CNT_W = 4
) (
   input  logic             skip_if,
   input  logic             skip_d,
   input  logic [CNT_W-1:0] if_cnt,
   input  logic [CNT_W-1:0] d_cnt,
   output logic             drained
);
   logic if_idle;
   logic d_idle;

   assign if_idle = skip_if | (if_cnt == '0);
   assign d_idle  = skip_d  | (d_cnt  == '0);
   assign drained = if_idle & d_idle;
endmodule

// File: rtl/barrier_settle_tmr.sv
`timescale 1ns/1ps
module barrier_settle_tmr #(
   parameter int CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic last
);
   generate
      if (CYC > 0) begin : g_cnt
         localparam int TW = (CYC > 1) ? $clog2(CYC) : 1;
         logic [TW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (start) begin
               cnt_q <= TW'(CYC - 1);
            end else if (run && (cnt_q != '0)) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign last = (cnt_q == '0);
      end else begin : g_none
         logic unused_tmr;
         assign unused_tmr = ^{clk, rst_n, start, run};
         assign last       = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/barrier_lp_out.sv
`timescale 1ns/1ps
module barrier_lp_out #(
   parameter int WAKE_W = 2
) (
   input  logic               asleep,
   input  barrier_pkg::lp_e   code,
   input  logic [WAKE_W-1:0]  wake,
   output logic               lp_sleep,
   output logic               lp_hibernate,
   output logic               lp_suspend
);
   import barrier_pkg::*;

   logic hold;

   assign hold         = asleep & ~(|wake);
   assign lp_sleep     = hold & (code == LP_SLEEP);
   assign lp_hibernate = hold & (code == LP_HIB);
   assign lp_suspend   = hold & (code == LP_SUSP);
endmodule

// File: rtl/barrier_sleep_ctl.sv
`timescale 1ns/1ps
module barrier_sleep_ctl #(
   parameter int          CNT_W        = 4,
   parameter int          WAKE_W       = 2,
   parameter int          SIMPLE_LAT   = 2,
   parameter int          COHERENT_LAT = 8,
   parameter bit          COHERENT     = 1'b0,
   parameter logic [4:0]  PRIV_CODE    = 5'b00111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [4:0]        req_imm,
   input  logic [CNT_W-1:0]  ifetch_pend,
   input  logic [CNT_W-1:0]  data_pend,
   input  logic              user_mode,
   input  logic              mmu_on,
   input  logic [WAKE_W-1:0] wake,
   output logic              stall,
   output logic              btc_flush,
   output logic              pfb_flush,
   output logic              lp_sleep,
   output logic              lp_hibernate,
   output logic              lp_suspend,
   output logic              exc_valid,
   output logic [4:0]        exc_code,
   output logic              pc_adv
);
   import barrier_pkg::*;

   localparam int FIX_LAT    = COHERENT ? COHERENT_LAT : SIMPLE_LAT;
   localparam int SETTLE_CYC = FIX_LAT - 2;
   localparam bit HAS_SETTLE = (SETTLE_CYC > 0);

   initial begin : p_param_chk
      assert (CNT_W >= 1)        else $fatal(1, "CNT_W must be at least 1");
      assert (WAKE_W >= 1)       else $fatal(1, "WAKE_W must be at least 1");
      assert (SIMPLE_LAT >= 2)   else $fatal(1, "SIMPLE_LAT must be at least 2");
      assert (COHERENT_LAT >= 2) else $fatal(1, "COHERENT_LAT must be at least 2");
   end

   bst_e       state_q, state_d;
   logic [1:0] skip_q;
   lp_e        lp_q;
   logic       drained;
   logic       tmr_last;
   logic       fault;
   logic       accept;
   logic       wake_any;
   logic       unused_imm;
   bst_e       fin_state;

   assign unused_imm = req_imm[2];
   assign accept     = req_valid & (state_q == ST_IDLE);
   assign fault      = mmu_on & user_mode & req_imm[4];
   assign wake_any   = |wake;
   assign fin_state  = (lp_q != LP_NONE) ? ST_SLEEP : ST_DONE;

   barrier_drain #(.CNT_W(CNT_W)) u_drain (
      .skip_if (skip_q[0]),
      .skip_d  (skip_q[1]),
      .if_cnt  (ifetch_pend),
      .d_cnt   (data_pend),
      .drained (drained)
   );

   barrier_settle_tmr #(.CYC(SETTLE_CYC)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .start ((state_q == ST_DRAIN) & drained),
      .run   (state_q == ST_SETTLE),
      .last  (tmr_last)
   );

   barrier_lp_out #(.WAKE_W(WAKE_W)) u_lp (
      .asleep       (state_q == ST_SLEEP),
      .code         (lp_q),
      .wake         (wake),
      .lp_sleep     (lp_sleep),
      .lp_hibernate (lp_hibernate),
      .lp_suspend   (lp_suspend)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (req_valid) state_d = fault ? ST_EXC : ST_DRAIN;
         ST_DRAIN:  if (drained)   state_d = HAS_SETTLE ? ST_SETTLE : fin_state;
         ST_SETTLE: if (tmr_last)  state_d = fin_state;
         ST_SLEEP:  if (wake_any)  state_d = ST_DONE;
         ST_DONE:   state_d = ST_IDLE;
         ST_EXC:    state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         skip_q  <= 2'b00;
         lp_q    <= LP_NONE;
      end else begin
         state_q <= state_d;
         if (accept) begin
            skip_q <= req_imm[1:0];
            lp_q   <= lp_e'(req_imm[4:3]);
         end
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign stall     = (state_q != ST_IDLE);
   assign pc_adv    = (state_q == ST_DONE);
   assign btc_flush = pc_adv & (skip_q == 2'b10);
   assign pfb_flush = pc_adv & (skip_q == 2'b10);
   assign exc_valid = (state_q == ST_EXC);
   assign exc_code  = exc_valid ? PRIV_CODE : '0;
endmodule

// File: rtl/barrier_sleep_chk.sv
`timescale 1ns/1ps
module barrier_sleep_chk #(
   parameter int         WAKE_W    = 2,
   parameter logic [4:0] PRIV_CODE = 5'b00111
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [4:0]        req_imm,
   input logic              user_mode,
   input logic              mmu_on,
   input logic [WAKE_W-1:0] wake,
   input logic              stall,
   input logic              btc_flush,
   input logic              pfb_flush,
   input logic              lp_sleep,
   input logic              lp_hibernate,
   input logic              lp_suspend,
   input logic              exc_valid,
   input logic [4:0]        exc_code,
   input logic              pc_adv
);
   logic lp_any;
   logic take;
   logic priv_hit;

   assign lp_any   = lp_sleep | lp_hibernate | lp_suspend;
   assign take     = req_valid & req_ready;
   assign priv_hit = mmu_on & user_mode & req_imm[4];

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !pc_adv && !exc_valid) |=> (stall && !req_ready)); // R10
   AST_PC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pc_adv |=> (!pc_adv && req_ready)); // R4
   AST_LP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lp_sleep, lp_hibernate, lp_suspend})); // R6
   AST_LP_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      lp_any |-> (stall && !pc_adv)); // R6
   AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (|wake) |-> !lp_any); // R7
   AST_WAKE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      lp_any ##1 (|wake) |=> pc_adv); // R7
   AST_FLUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (btc_flush || pfb_flush) |-> (pc_adv && btc_flush && pfb_flush)); // R5
   AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (!pc_adv && !btc_flush && !lp_any && exc_code == PRIV_CODE)); // R8
   AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> (!exc_valid && req_ready)); // R8
   AST_FAULT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (take && priv_hit) |=> exc_valid); // R8
   AST_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !priv_hit) |=> (stall && !exc_valid)); // R9
endmodule

bind barrier_sleep_ctl barrier_sleep_chk #(
   .WAKE_W    (WAKE_W),
   .PRIV_CODE (PRIV_CODE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_imm      (req_imm),
   .user_mode    (user_mode),
   .mmu_on       (mmu_on),
   .wake         (wake),
   .stall        (stall),
   .btc_flush    (btc_flush),
   .pfb_flush    (pfb_flush),
   .lp_sleep     (lp_sleep),
   .lp_hibernate (lp_hibernate),
   .lp_suspend   (lp_suspend),
   .exc_valid    (exc_valid),
   .exc_code     (exc_code),
   .pc_adv       (pc_adv)
);

// File: tb/barrier_sleep_ctl_bench.sv
`timescale 1ns/1ps
module barrier_sleep_ctl_bench;
   localparam int         CNT_W  = 4;
   localparam int         WAKE_W = 3;
   localparam bit         COH    = 1'b1;
   localparam int         FIX    = COH ? 8 : 2;
   localparam logic [4:0] PCODE  = 5'b00111;
   localparam logic [CNT_W-1:0] VAL = 4'd5;
   localparam logic [CNT_W-1:0] IGN = 4'd9;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic [4:0]        req_imm;
   logic [CNT_W-1:0]  ifetch_pend;
   logic [CNT_W-1:0]  data_pend;
   logic              user_mode;
   logic              mmu_on;
   logic [WAKE_W-1:0] wake;
   logic              stall, btc_flush, pfb_flush;
   logic              lp_sleep, lp_hibernate, lp_suspend;
   logic              exc_valid, pc_adv;
   logic [4:0]        exc_code;

   barrier_sleep_ctl #(
      .CNT_W(CNT_W), .WAKE_W(WAKE_W), .COHERENT(COH), .PRIV_CODE(PCODE)
   ) u_barrier_sleep_ctl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_imm(req_imm), .ifetch_pend(ifetch_pend), .data_pend(data_pend),
      .user_mode(user_mode), .mmu_on(mmu_on), .wake(wake), .stall(stall),
      .btc_flush(btc_flush), .pfb_flush(pfb_flush), .lp_sleep(lp_sleep),
      .lp_hibernate(lp_hibernate), .lp_suspend(lp_suspend),
      .exc_valid(exc_valid), .exc_code(exc_code), .pc_adv(pc_adv)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done_f = 1'b0;

   typedef struct {
      string tag;
      int    busy;
      int    lpc;
      int    lpm;
      int    flush;
      int    pcs;
      int    exc;
   } exp_t;

   exp_t sb[$];

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   function automatic int lp_on();
      return int'(lp_sleep | lp_hibernate | lp_suspend);
   endfunction

   task automatic set_cnt(input logic [4:0] imm, input int k, input int n);
      ifetch_pend = imm[0] ? IGN : ((k < n) ? VAL : '0);
      data_pend   = imm[1] ? IGN : ((k < n) ? VAL : '0);
   endtask

   // scoreboard monitor
   initial begin : mon
      int busy, lpc, lpm, fb, fp, pcs, exc, code;
      exp_t e;
      busy = 0; lpc = 0; lpm = 0; fb = 0; fp = 0; pcs = 0; exc = 0; code = 0;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && stall) begin
            busy++;
            if (lp_on() != 0) begin
               lpc++;
               lpm = lpm | int'({lp_suspend, lp_hibernate, lp_sleep});
            end
            if (pc_adv) begin
               pcs++;
               fb = fb | int'(btc_flush);
               fp = fp | int'(pfb_flush);
            end
            if (exc_valid) begin
               exc  = 1;
               code = int'(exc_code);
            end
         end else if (busy > 0) begin
            if (sb.size() == 0) begin
               chk("R10 unexpected operation", 1, 0);
            end else begin
               e = sb.pop_front();
               chk({e.tag, " R4 stall cycles"}, busy, e.busy);
               chk({e.tag, " R4 pc_adv count"}, pcs, e.pcs);
               chk({e.tag, " R5 btc_flush"}, fb, e.flush);
               chk({e.tag, " R5 pfb_flush"}, fp, e.flush);
               chk({e.tag, " R6 low-power cycles"}, lpc, e.lpc);
               chk({e.tag, " R6 low-power output"}, lpm, e.lpm);
               chk({e.tag, " R8 exception"}, exc, e.exc);
               if (e.exc != 0) chk({e.tag, " R8 exception code"}, code, int'(PCODE));
            end
            busy = 0; lpc = 0; lpm = 0; fb = 0; fp = 0; pcs = 0; exc = 0; code = 0;
         end
      end
   end

   // driver: called at a negedge with the unit idle or about to go idle
   task automatic issue(input string tag, input logic [4:0] imm, input int n,
                        input int w, input bit usr, input bit mmu,
                        input bit chain, input logic [4:0] nxt);
      exp_t e;
      bit   flt;
      int   neff;
      bit   lp;
      flt  = mmu && usr && imm[4];
      neff = (imm[1:0] == 2'b11) ? 0 : n;
      lp   = (imm[4:3] != 2'b00);
      e.tag   = tag;
      e.exc   = int'(flt);
      e.pcs   = flt ? 0 : 1;
      e.flush = (!flt && imm[1:0] == 2'b10) ? 1 : 0;
      e.lpc   = (lp && !flt) ? w + 1 : 0;
      e.lpm   = (lp && !flt) ? ((imm[4:3] == 2'b10) ? 1 : (imm[4:3] == 2'b01) ? 2 : 4) : 0;
      e.busy  = flt ? 1 : FIX + neff + e.lpc;
      sb.push_back(e);
      user_mode = usr;
      mmu_on    = mmu;
      req_imm   = imm;
      req_valid = 1'b1;
      set_cnt(imm, -1, n);
      while (!req_ready) @(negedge clk);
      for (int k = 0; k <= n; k++) begin
         @(negedge clk);
         if (chain) req_imm = nxt;
         else req_valid = 1'b0;
         set_cnt(imm, k, n);
         if (chain && stall) chk({tag, " R10 ready low while busy"}, int'(req_ready), 0);
      end
      if (lp && !flt) begin
         while (lp_on() == 0) @(negedge clk);
         repeat (w) @(negedge clk);
         wake = WAKE_W'(3'b001 << (w % 3));
         #1;
         chk({tag, " R7 output drops with wake"}, lp_on(), 0);
         chk({tag, " R7 still stalled at wake"}, int'(stall), 1);
         @(negedge clk);
         wake = '0;
         chk({tag, " R7 pc_adv after wake"}, int'(pc_adv), 1);
      end
      while (stall) begin
         if (chain) chk({tag, " R10 ready low while busy"}, int'(req_ready), 0);
         @(negedge clk);
      end
      if (!chain) begin
         ifetch_pend = '0;
         data_pend   = '0;
      end
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!done_f) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin : drv
      rst_n = 1'b0; req_valid = 1'b0; req_imm = '0; ifetch_pend = '0;
      data_pend = '0; user_mode = 1'b0; mmu_on = 1'b0; wake = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset req_ready", int'(req_ready), 1);
      chk("R1 reset stall", int'(stall), 0);
      chk("R1 reset pc_adv", int'(pc_adv), 0);
      chk("R1 reset flush", int'(btc_flush | pfb_flush), 0);
      chk("R1 reset low-power", lp_on(), 0);
      chk("R1 reset exception", int'(exc_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset req_ready", int'(req_ready), 1);

      issue("R2 instr wait",      5'd2,  3, 0, 0, 0, 0, 5'd0);
      issue("R3 data wait",       5'd1,  4, 0, 0, 0, 0, 5'd0);
      issue("R2 both sides",      5'd0,  2, 0, 0, 0, 0, 5'd0);
      issue("R3 no side",         5'd3,  5, 0, 0, 0, 0, 5'd0);
      issue("R6 sleep",           5'd16, 1, 3, 0, 1, 0, 5'd0);
      issue("R9 hibernate user",  5'd8,  0, 0, 1, 1, 0, 5'd0);
      issue("R9 suspend no mmu",  5'd24, 2, 2, 1, 0, 0, 5'd0);
      issue("R8 sleep fault",     5'd16, 2, 0, 1, 1, 0, 5'd0);
      issue("R8 suspend fault",   5'd24, 0, 0, 1, 1, 0, 5'd0);
      issue("R5 flush then sleep", 5'd18, 1, 1, 0, 0, 0, 5'd0);
      issue("R9 low imm user",    5'd2,  1, 0, 1, 1, 0, 5'd0);
      issue("R10 held first",     5'd1,  6, 0, 0, 0, 1, 5'd0);
      issue("R10 held second",    5'd0,  0, 0, 0, 0, 0, 5'd0);

      repeat (4) @(negedge clk);
      chk("R10 all operations completed", sb.size(), 0);
      done_f = 1'b1;
      summary();
      $finish;
   end
endmodule